// File: doc/BRIEF.md
# PHY Test-Port Write Sequencer

This block writes configuration into a PHY through its serial test port. The port has three wires from the block: a test clock, a test enable and an 8-bit test data bus. A write transaction is one 8-bit code followed by zero or more 8-bit data bytes. The block produces the edges of that transaction in a fixed order. Every edge is held for a programmable number of system clocks so that the PHY's setup and hold needs are met.

The host starts a transaction with a request that carries the code, a byte count and a step length. It then supplies the data bytes one at a time through a valid/ready handshake. A late byte stalls the sequencer and leaves the port unchanged. The block reports busy while a transaction runs and pulses done once at its end. It also drives the PHY's test-clear line. That line follows a clear input and blocks new requests while it is high.

Top module: `tport_seq`

## Requirements
- R1: While `rst_n` is low on a clock edge, and after that edge, `tp_clk`, `tp_en`, `tp_din`, `busy` and `done` are 0, `test_clr` is 1 and `req_ready` is 0.
- R2: `test_clr` takes the value of `clr_in` one clock later. While `test_clr` is 1, `req_ready` is 0 and a request has no effect: the port stays unchanged and `busy` stays 0.
- R3: The cycle after a request is accepted, the code phase begins. It is five steps in this order: `tp_clk` goes to 1; `tp_din` takes the code; `tp_en` goes to 1; `tp_clk` goes to 0; `tp_en` goes to 0.
- R4: Each data byte takes three steps after the code phase: `tp_clk` is 0; `tp_din` takes the byte; `tp_clk` goes to 1. `tp_en` stays 0 for every data step.
- R5: Each step lasts `step_len` clocks, and a value of 0 acts as 1. The block captures `req_code`, `req_count` and `step_len` when it accepts a request.
- R6: With `req_count` equal to 0, only the five code steps run. `done` then rises with `tp_clk` at 0.
- R7: `byte_ready` is 1 only in the last cycle of a byte's first step, and it stays 1 until `byte_valid` is seen. While the block waits, `tp_clk` and `tp_en` stay 0 and `tp_din` does not change.
- R8: `busy` is 1 from the cycle after acceptance until the final step ends. `done` is 1 for exactly the one cycle in which `busy` first reads 0. After a data byte, `tp_clk` stays 1 while the block is idle.
- R9: `req_ready` is 1 only when the block is idle and `test_clr` is 0. This lets the same code be written again in a later transaction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| clr_in | input | 1 | Requested level of the PHY test-clear line |
| step_len | input | STEP_W | System clocks per step (0 acts as 1) |
| req_valid | input | 1 | Transaction request present |
| req_ready | output | 1 | Request can be accepted |
| req_code | input | 8 | Test code to write |
| req_count | input | CNT_W | Number of data bytes after the code |
| byte_valid | input | 1 | Data byte present |
| byte_ready | output | 1 | Data byte taken this cycle |
| byte_data | input | 8 | Data byte |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-cycle end-of-transaction pulse |
| test_clr | output | 1 | PHY test-clear line |
| tp_clk | output | 1 | PHY test clock |
| tp_en | output | 1 | PHY test enable |
| tp_din | output | 8 | PHY test data input |

## Verification
The bench checks every port value on every cycle of each transaction against a step timeline it works out from the code, count and step length. It walks a table that mixes byte counts of 0, 1, 2 and 3 with step lengths of 0, 1, 2, 3 and 4. Count 0 separates a code-only write from a data write. The different step lengths show whether each edge is held for the right number of clocks, and whether a step length of 0 is read as 1. One code is written twice, to show that a repeated code starts a full new sequence. Separate directed tests hold `clr_in` high while a request is offered, and withhold a data byte. The withheld byte shows whether the stall point leaves the port frozen with the test clock low.

// File: rtl/tport_pkg.sv
// Package: shared state type for the PHY test-port sequencer.
// Assumes nothing beyond 8-bit test codes and data bytes.
package tport_pkg;

    // Sequencer steps; code phase first, then three steps per data byte.
    typedef enum logic [3:0] {
        ST_IDLE   = 4'd0,
        ST_CK_HI  = 4'd1,
        ST_CODE   = 4'd2,
        ST_EN_HI  = 4'd3,
        ST_CK_LO  = 4'd4,
        ST_EN_LO  = 4'd5,
        ST_D_LOW  = 4'd6,
        ST_D_BYTE = 4'd7,
        ST_D_HIGH = 4'd8
    } step_e;

endpackage

// File: rtl/tport_clr.sv
// Module: registers the PHY test-clear line from its control input.
// Assumes the line must read high out of reset (PHY in shutdown).
module tport_clr (
    input  logic clk,
    input  logic rst_n,
    input  logic clr_in,
    output logic test_clr
);

    // Hold clear high in reset, otherwise follow the control one cycle later.
    always_ff @(posedge clk) begin
        if (!rst_n) test_clr <= 1'b1;
        else        test_clr <= clr_in;
    end

endmodule

// File: rtl/tport_timer.sv
// Module: step-length down counter; tick is high in the last cycle of a step.
// Assumes load is pulsed on the edge that starts every step.
module tport_timer #(
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic [STEP_W-1:0] len,
    output logic              tick
);

    logic [STEP_W-1:0] cnt_q;
    logic [STEP_W-1:0] start_v;

    // A length of zero behaves as a one-cycle step.
    always_comb start_v = (len == '0) ? '0 : len - 1'b1;

    // Reload on a new step, otherwise count down to zero and hold.
    always_ff @(posedge clk) begin
        if (!rst_n)            cnt_q <= '0;
        else if (load)         cnt_q <= start_v;
        else if (cnt_q != '0)  cnt_q <= cnt_q - 1'b1;
    end

    assign tick = (cnt_q == '0);

    // R5: a running step counts down by exactly one per cycle.
    a_r5_countdown: assert property (@(posedge clk) disable iff (!rst_n)
        (!load && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

endmodule

// File: rtl/tport_fsm.sv
// Module: step sequencer that drives the test clock, enable and data bus.
// Assumes tick comes from a timer that this module reloads via load.
module tport_fsm #(
    parameter int CNT_W  = 4,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              test_clr,
    input  logic              tick,
    input  logic [STEP_W-1:0] step_len,
    input  logic              req_valid,
    input  logic [7:0]        req_code,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    output logic              req_ready,
    output logic              byte_ready,
    output logic              load,
    output logic [STEP_W-1:0] step_q,
    output logic              busy,
    output logic              done,
    output logic              tp_clk,
    output logic              tp_en,
    output logic [7:0]        tp_din
);
    import tport_pkg::*;

    step_e            state;
    logic [CNT_W-1:0] left_q;
    logic [7:0]       code_q;
    logic             accept;

    assign req_ready  = (state == ST_IDLE) && !test_clr;
    assign accept     = req_ready && req_valid;
    assign byte_ready = (state == ST_D_LOW) && tick;
    assign busy       = (state != ST_IDLE);

    // Reload the step timer on every step change.
    always_comb begin
        case (state)
            ST_IDLE:  load = accept;
            ST_D_LOW: load = tick && byte_valid;
            default:  load = tick;
        endcase
    end

    // Advance through the steps and update the port on each step entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= ST_IDLE;
            left_q <= '0;
            code_q <= '0;
            step_q <= '0;
            done   <= 1'b0;
            tp_clk <= 1'b0;
            tp_en  <= 1'b0;
            tp_din <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                ST_IDLE: if (accept) begin
                    state  <= ST_CK_HI;
                    tp_clk <= 1'b1;
                    left_q <= req_count;
                    code_q <= req_code;
                    step_q <= step_len;
                end
                ST_CK_HI: if (tick) begin
                    state  <= ST_CODE;
                    tp_din <= code_q;
                end
                ST_CODE: if (tick) begin
                    state <= ST_EN_HI;
                    tp_en <= 1'b1;
                end
                ST_EN_HI: if (tick) begin
                    state  <= ST_CK_LO;
                    tp_clk <= 1'b0;
                end
                ST_CK_LO: if (tick) begin
                    state <= ST_EN_LO;
                    tp_en <= 1'b0;
                end
                ST_EN_LO: if (tick) begin
                    if (left_q == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state  <= ST_D_LOW;
                        tp_clk <= 1'b0;
                    end
                end
                ST_D_LOW: if (tick && byte_valid) begin
                    state  <= ST_D_BYTE;
                    tp_din <= byte_data;
                end
                ST_D_BYTE: if (tick) begin
                    state  <= ST_D_HIGH;
                    tp_clk <= 1'b1;
                    left_q <= left_q - 1'b1;
                end
                ST_D_HIGH: if (tick) begin
                    if (left_q == '0) begin
                        state <= ST_IDLE;
                        done  <= 1'b1;
                    end else begin
                        state  <= ST_D_LOW;
                        tp_clk <= 1'b0;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R3: enable can only rise while the test clock is high.
    a_r3_en_under_clk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(tp_en) |-> tp_clk);

    // R3: the code on the bus holds while enable stays high.
    a_r3_code_stable: assert property (@(posedge clk) disable iff (!rst_n)
        (tp_en && $past(tp_en)) |-> $stable(tp_din));

    // R7: a byte is only taken with the test clock and enable low.
    a_r7_take_low: assert property (@(posedge clk) disable iff (!rst_n)
        byte_ready |-> (!tp_clk && !tp_en));

    // R8: done is a single-cycle pulse and comes with busy low.
    a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (!busy ##1 !done));

endmodule

// File: rtl/tport_seq.sv
// Top: PHY test-port write sequencer (code phase, data phases, test clear).
// Assumes the host holds byte_data stable while byte_valid is high.
module tport_seq #(
    parameter int CNT_W  = 4,
    parameter int STEP_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr_in,
    input  logic [STEP_W-1:0] step_len,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [7:0]        req_code,
    input  logic [CNT_W-1:0]  req_count,
    input  logic              byte_valid,
    output logic              byte_ready,
    input  logic [7:0]        byte_data,
    output logic              busy,
    output logic              done,
    output logic              test_clr,
    output logic              tp_clk,
    output logic              tp_en,
    output logic [7:0]        tp_din
);

    logic              tick;
    logic              load;
    logic [STEP_W-1:0] step_q;

    tport_clr u_clr (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr_in   (clr_in),
        .test_clr (test_clr)
    );

    tport_timer #(.STEP_W(STEP_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (load),
        .len   (load && !busy ? step_len : step_q),
        .tick  (tick)
    );

    tport_fsm #(.CNT_W(CNT_W), .STEP_W(STEP_W)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .test_clr   (test_clr),
        .tick       (tick),
        .step_len   (step_len),
        .req_valid  (req_valid),
        .req_code   (req_code),
        .req_count  (req_count),
        .byte_valid (byte_valid),
        .byte_data  (byte_data),
        .req_ready  (req_ready),
        .byte_ready (byte_ready),
        .load       (load),
        .step_q     (step_q),
        .busy       (busy),
        .done       (done),
        .tp_clk     (tp_clk),
        .tp_en      (tp_en),
        .tp_din     (tp_din)
    );

    // R2: no request is accepted while the clear line is high.
    a_r2_clr_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        test_clr |-> !req_ready);

    // R9: a request is taken only from idle.
    a_r9_idle_only: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> busy);

endmodule

// File: tb/tport_seq_tb.sv
// Bench for tport_seq: table-driven transactions, then directed tests.
module tport_seq_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int NV = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       clr_in = 1'b1;
    logic [3:0] step_len = '0;
    logic       req_valid = 1'b0;
    logic [7:0] req_code = '0;
    logic [3:0] req_count = '0;
    logic       byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       req_ready, byte_ready, busy, done, test_clr, tp_clk, tp_en;
    logic [7:0] tp_din;

    int checks = 0;
    int fails = 0;
    bit finished = 1'b0;
    logic [7:0] prev_din = '0;

    // code, byte count, step length
    localparam logic [15:0] VEC [NV] = '{
        {8'h44, 4'd1, 4'd1}, {8'hA5, 4'd2, 4'd3}, {8'h10, 4'd0, 4'd2},
        {8'h44, 4'd1, 4'd0}, {8'h3C, 4'd3, 4'd2}, {8'hFF, 4'd1, 4'd4}
    };

    tport_seq dut_i (
        .clk(clk), .rst_n(rst_n), .clr_in(clr_in), .step_len(step_len),
        .req_valid(req_valid), .req_ready(req_ready), .req_code(req_code),
        .req_count(req_count), .byte_valid(byte_valid), .byte_ready(byte_ready),
        .byte_data(byte_data), .busy(busy), .done(done), .test_clr(test_clr),
        .tp_clk(tp_clk), .tp_en(tp_en), .tp_din(tp_din)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [7:0] mk(input logic [7:0] code, input int j);
        return code ^ (8'h5A + 8'(j * 29));
    endfunction

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // Offers one transaction and checks the port on every cycle of it.
    task automatic run_txn(input logic [7:0] code, input int cnt, input int sl);
        int n = (sl == 0) ? 1 : sl;
        int total = (5 + 3 * cnt) * n;
        byte_valid = 1'b1;
        byte_data  = mk(code, 0);
        req_code   = code;
        req_count  = 4'(cnt);
        step_len   = 4'(sl);
        req_valid  = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        step_len  = 4'd7;   // R5: change after acceptance must not matter
        for (int cyc = 0; cyc <= total; cyc++) begin
            if (cyc < total) begin
                int k = cyc / n;
                logic ec, ee;
                logic [7:0] ed;
                if (k < 5) begin
                    ec = (k <= 2);
                    ee = (k == 2 || k == 3);
                    ed = (k == 0) ? prev_din : code;
                    chk({tp_clk, tp_en, tp_din} == {ec, ee, ed}, "R3 R5 code phase",
                        {tp_clk, tp_en, tp_din}, {ec, ee, ed});
                end else begin
                    int j = (k - 5) / 3;
                    int p = (k - 5) % 3;
                    if (p == 0 && cyc % n == 0) byte_data = mk(code, j);
                    ec = (p == 2);
                    ee = 1'b0;
                    ed = (p == 0) ? ((j == 0) ? code : mk(code, j - 1)) : mk(code, j);
                    chk({tp_clk, tp_en, tp_din} == {ec, ee, ed}, "R4 R5 data phase",
                        {tp_clk, tp_en, tp_din}, {ec, ee, ed});
                end
                chk(busy && !done, "R8 busy during txn", {busy, done}, 2'b10);
            end else begin
                chk(done && !busy, "R8 done at end", {busy, done}, 2'b01);
                chk(tp_clk == (cnt > 0), cnt == 0 ? "R6 code only clk low" : "R8 clk left high",
                    tp_clk, (cnt > 0));
            end
            @(negedge clk);
        end
        chk(!done, "R8 done one cycle", done, 0);
        prev_din = (cnt == 0) ? code : mk(code, cnt - 1);
        byte_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired actual=1 expected=0");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1: reset state
        chk({tp_clk, tp_en, tp_din, busy, done, test_clr, req_ready} == 13'b0000000000010,
            "R1 reset state", {tp_clk, tp_en, tp_din, busy, done, test_clr, req_ready},
            13'b0000000000010);
        rst_n = 1'b1;
        @(negedge clk);
        // R2: clear high blocks a request
        req_code = 8'h99; req_count = 4'd1; step_len = 4'd1; req_valid = 1'b1;
        repeat (3) begin
            @(negedge clk);
            chk(!req_ready && !busy && !tp_clk && tp_din == 8'h00, "R2 request ignored under clear",
                {req_ready, busy, tp_clk, tp_din}, 0);
        end
        req_valid = 1'b0;
        clr_in = 1'b0;
        chk(test_clr == 1'b1, "R2 clear still high", test_clr, 1);
        @(negedge clk);
        chk(test_clr == 1'b0 && req_ready, "R2 R9 clear released", {test_clr, req_ready}, 2'b01);

        for (int v = 0; v < NV; v++)
            run_txn(VEC[v][15:8], int'(VEC[v][7:4]), int'(VEC[v][3:0]));

        // R9: busy blocks new requests
        req_code = 8'h77; req_count = 4'd1; step_len = 4'd2; req_valid = 1'b1;
        byte_valid = 1'b0; byte_data = 8'hC3;
        @(negedge clk);
        req_valid = 1'b0;
        chk(!req_ready && busy, "R9 not ready while busy", {req_ready, busy}, 2'b01);
        // R7: stall with byte withheld; code phase cycles 0..9, D1 starts at 10
        repeat (10) @(negedge clk);
        chk(!byte_ready && !tp_clk, "R7 ready not in first cycle", {byte_ready, tp_clk}, 0);
        for (int s = 0; s < 6; s++) begin
            @(negedge clk);
            chk(byte_ready && !tp_clk && !tp_en && tp_din == 8'h77 && busy, "R7 stalled port frozen",
                {byte_ready, tp_clk, tp_en, tp_din, busy}, {3'b100, 8'h77, 1'b1});
        end
        byte_valid = 1'b1;
        @(negedge clk);
        byte_valid = 1'b0;
        chk(tp_din == 8'hC3 && !tp_clk && !byte_ready, "R7 byte taken after stall",
            {tp_clk, tp_din}, {1'b0, 8'hC3});
        repeat (2) @(negedge clk);
        chk(tp_clk && busy, "R4 clock rises after stall", {tp_clk, busy}, 2'b11);
        repeat (2) @(negedge clk);
        chk(done && !busy && tp_clk, "R8 done after stalled txn", {done, busy, tp_clk}, 3'b101);

        // R1: reset mid-idle returns clear high and port low
        rst_n = 1'b0;
        @(negedge clk);
        chk(!tp_clk && test_clr && !req_ready, "R1 reset again", {tp_clk, test_clr, req_ready}, 3'b010);
        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule